// File: doc/BRIEF.md
# Cooperative Eviction and Forwarding Controller

This block holds the tag state, replacement state and eviction policy of one private cache that takes part in a cooperative group of four caches. Every line carries two extra flags. The replica flag comes from the coherence directory and marks a line that another cache also holds. The forwarded flag marks a line that a sibling cache handed over. When a set is full, a fill picks its victim by true LRU. With a programmable probability the pick is biased instead toward the least recently used replicated line, because a copy of that line survives elsewhere.

A singlet victim is a line that is neither replicated nor forwarded. Such a victim is not discarded. It goes out on the forward port to one sibling, and the siblings are chosen in round-robin order. A sibling that receives a block installs it at its own LRU position and marks it as forwarded. A forwarded block therefore has exactly one chance. If it is not hit before it is evicted again, it is dropped. A local hit clears the forwarded mark, so the line becomes an ordinary resident again.

The directory, the network and the data arrays of the real cache lie outside this block. The block stores a small data word per line, only so that forwarded blocks carry a payload.

Top module: `coop_evict_fwd`

## Requirements
- R1: After reset every line is invalid. No response and no forward is issued, and a lookup to any set misses.
- R2: A request whose tag matches a valid line in its set reports rsp_hit=1 one cycle later, with rsp_way set to the matching way. The line becomes the most recently used line of its set and its forwarded flag is cleared. A fill that hits also overwrites the data and takes its replica flag from req_replica. rsp_data returns the data the line holds after the access.
- R3: A fill that misses in a set that still has an invalid way writes into the lowest-numbered invalid way. It reports rsp_evict=0 and makes that way the most recently used.
- R4: A fill that misses in a full set takes the current 8-bit value of a random source and then steps the source. The source resets to 0x01. Each step shifts left by one and XORs in 0x1D when bit 7 was 1. If the value is below thresh and at least one line in the set has its replica flag set, the oldest replicated line is evicted. rsp_evict=1 and rsp_evict_tag carry the victim's tag.
- R5: A replica-status update sets the replica flag of the valid line in rep_set whose tag equals rep_tag to rep_replica. An update that matches no line changes nothing.
- R6: An evicted line whose replica flag and forwarded flag are both 0 appears one cycle after its eviction on the forward port. The port carries fwd_valid=1 with the line's set, tag and data.
- R7: An evicted line whose replica flag or forwarded flag is 1 is dropped, and fwd_valid stays 0.
- R8: Forward destinations rotate over the other cores, starting at CORE_ID+1 after reset. Each next destination is CORE_ID+1+k mod CORES, where k counts the forwards issued so far modulo CORES-1. The local core is never a destination.
- R9: An incoming forwarded block whose tag is absent from its set is installed in the lowest invalid way, or else in the way that is least recently used. It gets the least recently used position, forwarded=1 and replica=0. A line it displaces follows R6 and R7. An incoming block whose tag is already present is ignored.
- R10: An incoming forwarded block that arrives in the same cycle as a local request is discarded.
- R11: When the bias of R4 does not apply, a full-set fill evicts the least recently used line of the set. Hits and allocations count as uses, and ages start as way index at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thresh | input | 8 | Bias threshold for replicated-victim choice |
| req_valid | input | 1 | Local request strobe |
| req_fill | input | 1 | 1 = fill on miss, 0 = lookup only |
| req_set | input | SET_W | Request set index |
| req_tag | input | TAG_W | Request tag |
| req_data | input | DATA_W | Fill data |
| req_replica | input | 1 | Replica status of the filled block |
| rep_valid | input | 1 | Replica-status update strobe |
| rep_set | input | SET_W | Update set index |
| rep_tag | input | TAG_W | Update tag |
| rep_replica | input | 1 | New replica flag |
| fin_valid | input | 1 | Incoming forwarded block strobe |
| fin_set | input | SET_W | Incoming block set index |
| fin_tag | input | TAG_W | Incoming block tag |
| fin_data | input | DATA_W | Incoming block data |
| rsp_valid | output | 1 | Response to a local request |
| rsp_hit | output | 1 | Request hit |
| rsp_way | output | WAY_W | Hit or allocated way |
| rsp_data | output | DATA_W | Line data after the access |
| rsp_evict | output | 1 | A valid line was displaced by the fill |
| rsp_evict_tag | output | TAG_W | Tag of the displaced line |
| fwd_valid | output | 1 | Outgoing forwarded block strobe |
| fwd_dest | output | CORE_W | Destination core |
| fwd_set | output | SET_W | Forwarded block set index |
| fwd_tag | output | TAG_W | Forwarded block tag |
| fwd_data | output | DATA_W | Forwarded block data |

## Verification
The assertions take three things for granted about the inputs. A replica update never lands in the same cycle as a request to the same line. Incoming blocks and local requests overlap only when the discard rule is under test. The tags within one set stay distinct, which the install rules keep true as long as the inputs respect the first two points. The stimulus meets these conditions by issuing one operation per cycle. An incoming block is paired with a request only in the cases that deliberately exercise the discard rule.

// File: rtl/coop_pkg.sv
`timescale 1ns/1ps
package coop_pkg;
  localparam int unsigned RND_W = 8;
  localparam logic [RND_W-1:0] RND_SEED = 8'h01;
  localparam logic [RND_W-1:0] RND_TAPS = 8'h1D;

  typedef enum logic [1:0] {
    ACT_IDLE,
    ACT_HIT,
    ACT_ALLOC,
    ACT_INSTALL
  } act_e;
endpackage

// File: rtl/coop_rst_sync.sv
`timescale 1ns/1ps
module coop_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/coop_lfsr.sv
`timescale 1ns/1ps
module coop_lfsr #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] SEED = 1,
  parameter logic [W-1:0] TAPS = 'h1D
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] value
);
  logic [W-1:0] value_n;

  always_comb begin
    value_n = value;
    if (step) value_n = {value[W-2:0], 1'b0} ^ (value[W-1] ? TAPS : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= SEED;
    else if (step) value <= value_n;
  end
endmodule

// File: rtl/coop_way_match.sv
`timescale 1ns/1ps
module coop_way_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 8,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           way
);
  always_comb begin
    hit = 1'b0;
    way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (valid[i] && (tags[i] == tag)) begin
        hit = 1'b1;
        way = WAY_W'(i);
      end
    end
  end
endmodule

// File: rtl/coop_victim_sel.sv
`timescale 1ns/1ps
module coop_victim_sel #(
  parameter int unsigned WAYS = 4,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned AGE_W = WAY_W
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0]            repl,
  input  logic [WAYS-1:0][AGE_W-1:0] ages,
  input  logic                       bias,
  output logic [WAY_W-1:0]           way,
  output logic                       way_empty
);
  logic             inv_found, rep_found;
  logic [WAY_W-1:0] inv_way, rep_way, lru_way;
  logic [AGE_W-1:0] rep_age;

  always_comb begin
    inv_found = 1'b0;
    inv_way   = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        inv_found = 1'b1;
        inv_way   = WAY_W'(i);
      end
    end
  end

  always_comb begin
    rep_found = 1'b0;
    rep_way   = '0;
    rep_age   = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (valid[i] && repl[i] && (!rep_found || (ages[i] > rep_age))) begin
        rep_found = 1'b1;
        rep_way   = WAY_W'(i);
        rep_age   = ages[i];
      end
    end
  end

  always_comb begin
    lru_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (ages[i] == AGE_W'(WAYS - 1)) lru_way = WAY_W'(i);
    end
  end

  always_comb begin
    way_empty = inv_found;
    if (inv_found)              way = inv_way;
    else if (bias && rep_found) way = rep_way;
    else                        way = lru_way;
  end
endmodule

// File: rtl/coop_evict_fwd.sv
`timescale 1ns/1ps
module coop_evict_fwd
  import coop_pkg::*;
#(
  parameter int unsigned SETS    = 4,
  parameter int unsigned WAYS    = 4,
  parameter int unsigned TAG_W   = 8,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CORES   = 4,
  parameter int unsigned CORE_ID = 0,
  localparam int unsigned SET_W  = $clog2(SETS),
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned AGE_W  = WAY_W,
  localparam int unsigned CORE_W = $clog2(CORES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RND_W-1:0]  thresh,
  input  logic              req_valid,
  input  logic              req_fill,
  input  logic [SET_W-1:0]  req_set,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_replica,
  input  logic              rep_valid,
  input  logic [SET_W-1:0]  rep_set,
  input  logic [TAG_W-1:0]  rep_tag,
  input  logic              rep_replica,
  input  logic              fin_valid,
  input  logic [SET_W-1:0]  fin_set,
  input  logic [TAG_W-1:0]  fin_tag,
  input  logic [DATA_W-1:0] fin_data,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_evict,
  output logic [TAG_W-1:0]  rsp_evict_tag,
  output logic              fwd_valid,
  output logic [CORE_W-1:0] fwd_dest,
  output logic [SET_W-1:0]  fwd_set,
  output logic [TAG_W-1:0]  fwd_tag,
  output logic [DATA_W-1:0] fwd_data
);
  typedef logic [WAYS-1:0][AGE_W-1:0] age_row_t;

  // age helpers: 0 is most recent, WAYS-1 is least recent
  function automatic age_row_t age_touch(input age_row_t a, input logic [WAY_W-1:0] w);
    age_row_t r;
    for (int i = 0; i < WAYS; i++) begin
      if (i == int'(w))    r[i] = '0;
      else if (a[i] < a[w]) r[i] = a[i] + AGE_W'(1);
      else                  r[i] = a[i];
    end
    return r;
  endfunction

  function automatic age_row_t age_demote(input age_row_t a, input logic [WAY_W-1:0] w);
    age_row_t r;
    for (int i = 0; i < WAYS; i++) begin
      if (i == int'(w))     r[i] = AGE_W'(WAYS - 1);
      else if (a[i] > a[w]) r[i] = a[i] - AGE_W'(1);
      else                  r[i] = a[i];
    end
    return r;
  endfunction

  logic rst_core_n;

  logic [SETS-1:0][WAYS-1:0]             valid_q, valid_n;
  logic [SETS-1:0][WAYS-1:0]             rep_q, rep_n;
  logic [SETS-1:0][WAYS-1:0]             fwdb_q, fwdb_n;
  age_row_t [SETS-1:0]                   age_q, age_n;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [SETS-1:0][WAYS-1:0][DATA_W-1:0] data_q;
  logic [CORE_W-1:0]                     rr_q, rr_n;
  logic                                  state_en;

  logic              wr_en;
  logic [SET_W-1:0]  wr_set;
  logic [WAY_W-1:0]  wr_way;
  logic [TAG_W-1:0]  wr_tag;
  logic [DATA_W-1:0] wr_data;

  logic              req_hit, fin_hit, vic_empty, bias, rnd_step;
  logic [WAY_W-1:0]  req_hit_way, fin_hit_way, vic_way;
  logic [SET_W-1:0]  sel_set;
  logic [RND_W-1:0]  rnd;
  act_e              act;
  logic              ev_line, ev_send;

  logic              rsp_valid_n, rsp_hit_n, rsp_evict_n, fwd_valid_n;
  logic [WAY_W-1:0]  rsp_way_n;
  logic [DATA_W-1:0] rsp_data_n, fwd_data_n;
  logic [TAG_W-1:0]  rsp_evict_tag_n, fwd_tag_n;
  logic [CORE_W-1:0] fwd_dest_n;

  coop_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  coop_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_req_match (
    .valid (valid_q[req_set]),
    .tags  (tag_q[req_set]),
    .tag   (req_tag),
    .hit   (req_hit),
    .way   (req_hit_way)
  );

  coop_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fin_match (
    .valid (valid_q[fin_set]),
    .tags  (tag_q[fin_set]),
    .tag   (fin_tag),
    .hit   (fin_hit),
    .way   (fin_hit_way)
  );

  assign sel_set = req_valid ? req_set : fin_set;
  assign bias    = req_valid && (rnd < thresh);

  coop_victim_sel #(.WAYS(WAYS)) u_victim (
    .valid     (valid_q[sel_set]),
    .repl      (rep_q[sel_set]),
    .ages      (age_q[sel_set]),
    .bias      (bias),
    .way       (vic_way),
    .way_empty (vic_empty)
  );

  coop_lfsr #(.W(RND_W), .SEED(RND_SEED), .TAPS(RND_TAPS)) u_rnd (
    .clk   (clk),
    .rst_n (rst_core_n),
    .step  (rnd_step),
    .value (rnd)
  );

  // action decode: a local request always wins over an incoming block
  always_comb begin
    act = ACT_IDLE;
    if (req_valid) begin
      if (req_hit)       act = ACT_HIT;
      else if (req_fill) act = ACT_ALLOC;
    end else if (fin_valid && !fin_hit) begin
      act = ACT_INSTALL;
    end
  end

  assign rnd_step = (act == ACT_ALLOC) && !vic_empty;
  assign ev_line  = ((act == ACT_ALLOC) || (act == ACT_INSTALL)) && valid_q[sel_set][vic_way];
  assign ev_send  = ev_line && !rep_q[sel_set][vic_way] && !fwdb_q[sel_set][vic_way];
  assign state_en = (act != ACT_IDLE) || rep_valid;

  always_comb begin
    valid_n = valid_q;
    rep_n   = rep_q;
    fwdb_n  = fwdb_q;
    age_n   = age_q;
    wr_en   = 1'b0;
    wr_set  = sel_set;
    wr_way  = vic_way;
    wr_tag  = req_tag;
    wr_data = req_data;
    if (rep_valid) begin
      for (int w = 0; w < WAYS; w++) begin
        if (valid_q[rep_set][w] && (tag_q[rep_set][w] == rep_tag)) rep_n[rep_set][w] = rep_replica;
      end
    end
    case (act)
      ACT_HIT: begin
        fwdb_n[req_set][req_hit_way] = 1'b0;
        age_n[req_set] = age_touch(age_q[req_set], req_hit_way);
        if (req_fill) begin
          rep_n[req_set][req_hit_way] = req_replica;
          wr_en  = 1'b1;
          wr_way = req_hit_way;
        end
      end
      ACT_ALLOC: begin
        valid_n[req_set][vic_way] = 1'b1;
        rep_n[req_set][vic_way]   = req_replica;
        fwdb_n[req_set][vic_way]  = 1'b0;
        age_n[req_set] = age_touch(age_q[req_set], vic_way);
        wr_en = 1'b1;
      end
      ACT_INSTALL: begin
        valid_n[fin_set][vic_way] = 1'b1;
        rep_n[fin_set][vic_way]   = 1'b0;
        fwdb_n[fin_set][vic_way]  = 1'b1;
        age_n[fin_set] = age_demote(age_q[fin_set], vic_way);
        wr_en   = 1'b1;
        wr_tag  = fin_tag;
        wr_data = fin_data;
      end
      default: ;
    endcase
  end

  always_comb begin
    rsp_valid_n     = req_valid;
    rsp_hit_n       = req_valid && req_hit;
    rsp_way_n       = '0;
    rsp_data_n      = '0;
    rsp_evict_n     = ev_line && (act == ACT_ALLOC);
    rsp_evict_tag_n = rsp_evict_n ? tag_q[sel_set][vic_way] : '0;
    if (act == ACT_HIT) begin
      rsp_way_n  = req_hit_way;
      rsp_data_n = req_fill ? req_data : data_q[req_set][req_hit_way];
    end else if (act == ACT_ALLOC) begin
      rsp_way_n  = vic_way;
      rsp_data_n = req_data;
    end
    fwd_valid_n = ev_send;
    fwd_tag_n   = ev_send ? tag_q[sel_set][vic_way] : '0;
    fwd_data_n  = ev_send ? data_q[sel_set][vic_way] : '0;
    fwd_dest_n  = CORE_W'((CORE_ID + 1 + int'(rr_q)) % CORES);
    rr_n        = rr_q;
    if (ev_send) rr_n = (rr_q == CORE_W'(CORES - 2)) ? '0 : rr_q + CORE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      valid_n_reset : begin
        valid_q <= '0;
        rep_q   <= '0;
        fwdb_q  <= '0;
        rr_q    <= '0;
        for (int s = 0; s < SETS; s++) begin
          for (int w = 0; w < WAYS; w++) age_q[s][w] <= AGE_W'(w);
        end
      end
    end else if (state_en) begin
      valid_q <= valid_n;
      rep_q   <= rep_n;
      fwdb_q  <= fwdb_n;
      age_q   <= age_n;
      rr_q    <= rr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way]  <= wr_tag;
      data_q[wr_set][wr_way] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_way       <= '0;
      rsp_data      <= '0;
      rsp_evict     <= 1'b0;
      rsp_evict_tag <= '0;
      fwd_valid     <= 1'b0;
      fwd_dest      <= '0;
      fwd_set       <= '0;
      fwd_tag       <= '0;
      fwd_data      <= '0;
    end else begin
      rsp_valid     <= rsp_valid_n;
      rsp_hit       <= rsp_hit_n;
      rsp_way       <= rsp_way_n;
      rsp_data      <= rsp_data_n;
      rsp_evict     <= rsp_evict_n;
      rsp_evict_tag <= rsp_evict_tag_n;
      fwd_valid     <= fwd_valid_n;
      fwd_dest      <= ev_send ? fwd_dest_n : '0;
      fwd_set       <= ev_send ? sel_set : '0;
      fwd_tag       <= fwd_tag_n;
      fwd_data      <= fwd_data_n;
    end
  end
endmodule

// File: rtl/coop_evict_fwd_chk.sv
`timescale 1ns/1ps
module coop_evict_fwd_chk #(
  parameter int unsigned CORES   = 4,
  parameter int unsigned CORE_ID = 0,
  localparam int unsigned CORE_W = $clog2(CORES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_fill,
  input logic              fin_valid,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_evict,
  input logic              fwd_valid,
  input logic [CORE_W-1:0] fwd_dest
);
  logic              have_last_q;
  logic [CORE_W-1:0] last_q;
  logic [CORE_W-1:0] exp_next;

  always_comb begin
    exp_next = CORE_W'((int'(last_q) + 1) % CORES);
    if (exp_next == CORE_W'(CORE_ID)) exp_next = CORE_W'((int'(exp_next) + 1) % CORES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_last_q <= 1'b0;
      last_q      <= '0;
    end else if (fwd_valid) begin
      have_last_q <= 1'b1;
      last_q      <= fwd_dest;
    end
  end

  // R8
  fwd_not_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (fwd_dest != CORE_W'(CORE_ID)));

  // R8
  rr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && have_last_q) |-> (fwd_dest == exp_next));

  // R2
  hit_no_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> !rsp_evict);

  // R1
  rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  // R10
  fwd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> ($past(req_valid && req_fill) || $past(fin_valid && !req_valid)));
endmodule

bind coop_evict_fwd coop_evict_fwd_chk #(.CORES(CORES), .CORE_ID(CORE_ID)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_fill  (req_fill),
  .fin_valid (fin_valid),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_evict (rsp_evict),
  .fwd_valid (fwd_valid),
  .fwd_dest  (fwd_dest)
);

// File: tb/test_coop_evict_fwd.sv
`timescale 1ns/1ps
module test_coop_evict_fwd;
  localparam int SETS = 2, WAYS = 4, TAG_W = 4, DATA_W = 8, CORES = 4, CORE_ID = 1;
  localparam int SET_W = $clog2(SETS), WAY_W = $clog2(WAYS), CORE_W = $clog2(CORES);

  logic clk, rst_n;
  logic [7:0] thresh;
  logic req_valid, req_fill, req_replica, rep_valid, rep_replica, fin_valid;
  logic [SET_W-1:0] req_set, rep_set, fin_set;
  logic [TAG_W-1:0] req_tag, rep_tag, fin_tag;
  logic [DATA_W-1:0] req_data, fin_data;
  logic rsp_valid, rsp_hit, rsp_evict, fwd_valid;
  logic [WAY_W-1:0] rsp_way;
  logic [DATA_W-1:0] rsp_data, fwd_data;
  logic [TAG_W-1:0] rsp_evict_tag, fwd_tag;
  logic [CORE_W-1:0] fwd_dest;
  logic [SET_W-1:0] fwd_set;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference state
  bit mv[SETS][WAYS], mr[SETS][WAYS], mf[SETS][WAYS];
  int mt[SETS][WAYS], md[SETS][WAYS], ma[SETS][WAYS];
  int m_rnd, m_rr, thr;
  int e_fv, e_fdest, e_fset, e_ftag, e_fdata;

  coop_evict_fwd #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W),
                   .CORES(CORES), .CORE_ID(CORE_ID)) i_coop_evict_fwd (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int find(input int s, input int t);
    for (int w = 0; w < WAYS; w++) if (mv[s][w] && mt[s][w] == t) return w;
    return -1;
  endfunction

  task automatic touch(input int s, input int w);
    int aw = ma[s][w];
    for (int i = 0; i < WAYS; i++) if (i != w && ma[s][i] < aw) ma[s][i]++;
    ma[s][w] = 0;
  endtask

  task automatic demote(input int s, input int w);
    int aw = ma[s][w];
    for (int i = 0; i < WAYS; i++) if (i != w && ma[s][i] > aw) ma[s][i]--;
    ma[s][w] = WAYS - 1;
  endtask

  // kind: 0 invalid way, 1 biased replica, 2 plain LRU
  task automatic pick(input int s, input bit bias, output int w, output int kind);
    int best_age = -1;
    w = -1;
    for (int i = WAYS - 1; i >= 0; i--) if (!mv[s][i]) w = i;
    if (w >= 0) begin kind = 0; return; end
    if (bias) begin
      for (int i = 0; i < WAYS; i++)
        if (mr[s][i] && ma[s][i] > best_age) begin best_age = ma[s][i]; w = i; end
      if (w >= 0) begin kind = 1; return; end
    end
    kind = 2;
    for (int i = 0; i < WAYS; i++) if (ma[s][i] == WAYS - 1) w = i;
  endtask

  task automatic evict_calc(input int s, input int w);
    e_fv = 0;
    if (mv[s][w] && !mr[s][w] && !mf[s][w]) begin
      e_fv = 1; e_fdest = (CORE_ID + 1 + m_rr) % CORES; e_fset = s;
      e_ftag = mt[s][w]; e_fdata = md[s][w];
      m_rr = (m_rr + 1) % (CORES - 1);
    end
  endtask

  task automatic chk_fwd(input string rq, input int ev);
    string lbl = rq;
    if (lbl == "") lbl = e_fv ? "R6" : (ev ? "R7" : "R6");
    chk(lbl, "fwd_valid", int'(fwd_valid), e_fv);
    if (e_fv && fwd_valid) begin
      chk("R8", "fwd_dest", int'(fwd_dest), e_fdest);
      chk("R6", "fwd_set", int'(fwd_set), e_fset);
      chk("R6", "fwd_tag", int'(fwd_tag), e_ftag);
      chk("R6", "fwd_data", int'(fwd_data), e_fdata);
    end
  endtask

  task automatic do_req(input bit fill, input int s, input int t, input int d, input bit rp,
                        input bit with_fin, input int ft, input string ovr);
    int w, kind, e_hit, e_way, e_data, e_ev, e_evt, val;
    string lbl;
    w = find(s, t); e_hit = (w >= 0); e_way = 0; e_data = 0; e_ev = 0; e_evt = 0; e_fv = 0;
    lbl = "R1";
    if (e_hit) begin
      lbl = "R2"; e_way = w;
      if (fill) begin md[s][w] = d; mr[s][w] = rp; end
      e_data = md[s][w]; mf[s][w] = 0; touch(s, w);
    end else if (fill) begin
      bit bias = 0;
      if (find_invalid(s)) pick(s, 0, w, kind);
      else begin
        val = m_rnd;
        m_rnd = ((m_rnd << 1) & 255) ^ (((m_rnd & 128) != 0) ? 29 : 0);
        bias = (val < thr);
        pick(s, bias, w, kind);
      end
      lbl = (kind == 0) ? "R3" : ((kind == 1) ? "R4" : "R11");
      if (mv[s][w]) begin e_ev = 1; e_evt = mt[s][w]; end
      evict_calc(s, w);
      mv[s][w] = 1; mt[s][w] = t; md[s][w] = d; mr[s][w] = rp; mf[s][w] = 0;
      touch(s, w); e_way = w; e_data = d;
    end
    if (ovr != "") lbl = ovr;
    @(negedge clk);
    req_valid = 1; req_fill = fill; req_set = SET_W'(s); req_tag = TAG_W'(t);
    req_data = DATA_W'(d); req_replica = rp;
    if (with_fin) begin fin_valid = 1; fin_set = SET_W'(s); fin_tag = TAG_W'(ft); fin_data = 8'hEE; end
    @(posedge clk); #1;
    req_valid = 0; fin_valid = 0;
    chk(lbl, "rsp_valid", int'(rsp_valid), 1);
    chk(lbl, "rsp_hit", int'(rsp_hit), e_hit);
    chk(lbl, "rsp_way", int'(rsp_way), e_way);
    chk(lbl, "rsp_data", int'(rsp_data), e_data);
    chk(lbl, "rsp_evict", int'(rsp_evict), e_ev);
    if (e_ev) chk(lbl, "rsp_evict_tag", int'(rsp_evict_tag), e_evt);
    chk_fwd(with_fin ? "R10" : "", e_ev);
  endtask

  function automatic bit find_invalid(input int s);
    for (int w = 0; w < WAYS; w++) if (!mv[s][w]) return 1;
    return 0;
  endfunction

  task automatic do_fin(input int s, input int t, input int d);
    int w, kind, ev;
    e_fv = 0; ev = 0;
    if (find(s, t) < 0) begin
      pick(s, 0, w, kind);
      ev = mv[s][w];
      evict_calc(s, w);
      mv[s][w] = 1; mt[s][w] = t; md[s][w] = d; mr[s][w] = 0; mf[s][w] = 1;
      demote(s, w);
    end
    @(negedge clk);
    fin_valid = 1; fin_set = SET_W'(s); fin_tag = TAG_W'(t); fin_data = DATA_W'(d);
    @(posedge clk); #1;
    fin_valid = 0;
    chk("R9", "rsp_valid idle", int'(rsp_valid), 0);
    chk_fwd(ev ? "" : "R9", ev);
  endtask

  task automatic do_rep(input int s, input int t, input bit rp);
    int w = find(s, t);
    if (w >= 0) mr[s][w] = rp;
    @(negedge clk);
    rep_valid = 1; rep_set = SET_W'(s); rep_tag = TAG_W'(t); rep_replica = rp;
    @(posedge clk); #1;
    rep_valid = 0;
    chk("R5", "rsp_valid idle", int'(rsp_valid), 0);
    chk("R5", "fwd_valid idle", int'(fwd_valid), 0);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int r;
    rst_n = 0; thresh = 0; thr = 0;
    req_valid = 0; req_fill = 0; req_set = 0; req_tag = 0; req_data = 0; req_replica = 0;
    rep_valid = 0; rep_set = 0; rep_tag = 0; rep_replica = 0;
    fin_valid = 0; fin_set = 0; fin_tag = 0; fin_data = 0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        mv[s][w] = 0; mr[s][w] = 0; mf[s][w] = 0; mt[s][w] = 0; md[s][w] = 0; ma[s][w] = w;
      end
    m_rnd = 1; m_rr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    chk("R1", "fwd_valid after reset", int'(fwd_valid), 0);
    do_req(0, 0, 0, 0, 0, 0, 0, "R1");
    do_req(0, 1, 3, 0, 0, 0, 0, "R1");

    // R5: replica update steers a biased eviction; unmatched update is harmless
    thr = 255; thresh = 8'd255;
    for (int t = 1; t <= 4; t++) do_req(1, 0, t, 16 * t, 0, 0, 0, "");
    do_rep(0, 3, 1);
    do_rep(0, 9, 1);
    do_req(1, 0, 5, 80, 0, 0, 0, "R5");

    // R11: plain LRU ordering with threshold 0
    thr = 0; thresh = 8'd0;
    for (int t = 1; t <= 4; t++) do_req(1, 1, t, t, 0, 0, 0, "");
    do_req(0, 1, 1, 0, 0, 0, 0, "R2");
    do_req(1, 1, 6, 66, 0, 0, 0, "R11");

    // R10: incoming block colliding with a request is discarded
    do_req(0, 1, 6, 0, 0, 1, 12, "R10");
    do_req(0, 1, 12, 0, 0, 0, 0, "R10");

    // R9: forwarded install at LRU, then a second eviction drops it (R7)
    do_fin(1, 13, 130);
    do_req(1, 1, 14, 140, 0, 0, 0, "R9");

    // sweep over thresholds with pseudo-random operations
    r = 16'hACE1;
    for (int ph = 0; ph < 3; ph++) begin
      thr = (ph == 0) ? 0 : ((ph == 1) ? 100 : 255);
      thresh = 8'(thr);
      for (int n = 0; n < 500; n++) begin
        int k, s, t, d;
        bit rp;
        r = ((r << 1) & 16'hFFFF) | (((r >> 15) ^ (r >> 13) ^ (r >> 12) ^ (r >> 10)) & 1);
        k = r % 8; s = (r >> 8) & 1; t = (r >> 4) % 6; d = (r >> 5) & 255; rp = r[3];
        case (k)
          0, 1: do_req(0, s, t, d, rp, 0, 0, "");
          2, 3, 4: do_req(1, s, t, d, rp, 0, 0, "");
          5: do_rep(s, t, rp);
          6: do_fin(s, t, d);
          default: do_req(r[2], s, t, d, rp, 1, (t + 1) % 6, "");
        endcase
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule